// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier

This block multiplies two 12-bit symbols in GF(2^12). The field is built as a degree-two extension of GF(2^6). Each symbol is treated as a pair of 6-bit halves. Four GF(64) multiplications and a few XORs produce the product halves. The block is the arithmetic core for a Reed-Solomon engine with 12-bit symbols. Other logic calls it for the products that syndrome and locator work need. Those tables and algorithms sit outside this block.

A second mode provides the code's "alpha power step". In this mode the first operand is multiplied by a fixed field constant, and the second operand is ignored. The one exception is a first operand of zero, which gives one.

Operands enter over a valid/ready stream, and products leave over another valid/ready stream. A transfer happens on a clock edge where valid and ready are both high. The upstream side must hold its operands and mode stable while valid is high and ready is low.

With the output register present (the default), the block holds one product. That product stays stable until it is taken. While a held product is blocked by a low `out_ready`, `in_ready` is low. With the register removed, the block is purely combinational: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`.

Top module: `tower_gf4k_mul`

## Requirements
- R1: GF(64) products reduce by x^6 = x + 1. As one example, operands 0x020 and 0x002 (both with a zero high half) give 0x003.
- R2: In multiply mode (`in_step` = 0), each operand is split into a high half H (bits 11..6) and a low half L (bits 5..0). The result's high half is (Ha^La)(Hb^Lb) ^ La·Lb. The result's low half is (Ha·Hb)·0x21 ^ La·Lb. All products here are GF(64) products.
- R3: In multiply mode, 0x001 is the identity, and a zero operand gives 0x000.
- R4: In multiply mode, a·b equals b·a, and a·(b^c) equals a·b ^ a·c.
- R5: In step mode (`in_step` = 1) with a nonzero `in_a`, the result is `in_a` multiplied by the constant 0xE01, whatever `in_b` holds. An input of 0x001 gives 0xE01.
- R6: In step mode with `in_a` = 0, the result is 0x001.
- R7: With the register present, a result appears on `out_valid`/`out_data` on the edge after the operands are accepted. Without the register, the result appears in the same cycle as the operands.
- R8: With the register present, a held result keeps `out_valid` high and `out_data` unchanged while `out_ready` is low, and `in_ready` is low during that time. Once the held result is taken, the next operands can be accepted on the same edge.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Block can accept operands |
| in_a | input | 12 | First operand |
| in_b | input | 12 | Second operand (ignored in step mode) |
| in_step | input | 1 | 1 selects the alpha-step mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 12 | Product |

## Verification
A fault in one of the four GF(64) sub-products corrupts only certain bit patterns, so the bench checks each result against an independent model. It uses hand-picked half patterns and random operands. It also checks the algebraic laws, which break whenever either half is combined wrongly.

A fault in the output register or its handshake shows up within one cycle of a transfer. It appears as a missing or extra `out_valid`, a result that changes while it is blocked, or `in_ready` staying high while a result is held.

// File: rtl/gf4k_pkg.sv
package gf4k_pkg;
  localparam int HALF_W   = 6;
  localparam int SYM_W    = 2 * HALF_W;
  localparam logic [HALF_W-1:0] BASE_POLY_LOW = 6'h03;
  localparam logic [HALF_W-1:0] EXT_TWIST     = 6'h21;
  localparam logic [SYM_W-1:0]  STEP_CONST    = 12'hE01;
  typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/gf_base_mul.sv
module gf_base_mul #(
  parameter int W = 6,
  parameter logic [W-1:0] POLY_LOW = 6'h03
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  always_comb begin
    logic [W-1:0] acc;
    logic [W-1:0] sh;
    acc = '0;
    sh  = b;
    for (int i = 0; i < W; i++) begin
      if (a[i]) acc = acc ^ sh;
      sh = sh[W-1] ? ({sh[W-2:0], 1'b0} ^ POLY_LOW) : {sh[W-2:0], 1'b0};
    end
    p = acc;
  end
endmodule

// File: rtl/gf_tower_mul.sv
module gf_tower_mul
  import gf4k_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter logic [HW-1:0] POLY_LOW = BASE_POLY_LOW,
  parameter logic [HW-1:0] TWIST = EXT_TWIST,
  localparam int SW = 2 * HW
) (
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  output logic [SW-1:0] z
);
  logic [HW-1:0] xh, xl, yh, yl;
  logic [HW-1:0] p_sum, p_low, p_high, p_tw;

  assign xh = x[SW-1:HW];
  assign xl = x[HW-1:0];
  assign yh = y[SW-1:HW];
  assign yl = y[HW-1:0];

  gf_base_mul #(.W(HW), .POLY_LOW(POLY_LOW)) u_sum  (.a(xh ^ xl), .b(yh ^ yl), .p(p_sum));
  gf_base_mul #(.W(HW), .POLY_LOW(POLY_LOW)) u_low  (.a(xl),      .b(yl),      .p(p_low));
  gf_base_mul #(.W(HW), .POLY_LOW(POLY_LOW)) u_high (.a(xh),      .b(yh),      .p(p_high));
  gf_base_mul #(.W(HW), .POLY_LOW(POLY_LOW)) u_tw   (.a(p_high),  .b(TWIST),   .p(p_tw));

  assign z = {p_sum ^ p_low, p_tw ^ p_low};
endmodule

// File: rtl/gf_out_stage.sv
module gf_out_stage #(
  parameter int W = 12,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  generate
    if (PIPE) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;
      assign s_ready = !vld_q || m_ready;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (s_ready) begin
          vld_q <= s_valid;
          if (s_valid) dat_q <= s_data;
        end
      end
      assign m_valid = vld_q;
      assign m_data  = dat_q;
    end else begin : g_wire
      assign s_ready = m_ready;
      assign m_valid = s_valid;
      assign m_data  = s_data;
    end
  endgenerate
endmodule

// File: rtl/tower_gf4k_mul.sv
module tower_gf4k_mul
  import gf4k_pkg::*;
#(
  parameter bit PIPE = 1'b1,
  parameter logic [SYM_W-1:0] STEP_K = STEP_CONST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_a,
  input  logic [SYM_W-1:0] in_b,
  input  logic             in_step,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data
);
  localparam logic [SYM_W-1:0] ONE = SYM_W'(1);

  logic [SYM_W-1:0] opnd_b, prod, result;

  assign opnd_b = in_step ? STEP_K : in_b;

  gf_tower_mul #(.HW(HALF_W), .POLY_LOW(BASE_POLY_LOW), .TWIST(EXT_TWIST)) u_core (
    .x(in_a), .y(opnd_b), .z(prod)
  );

  assign result = (in_step && in_a == '0) ? ONE : prod;

  gf_out_stage #(.W(SYM_W), .PIPE(PIPE)) u_out (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(result),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(out_data)
  );
endmodule

// File: rtl/tower_gf4k_mul_chk.sv
module tower_gf4k_mul_chk #(
  parameter bit PIPE = 1'b1,
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic         in_step,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  generate
    if (PIPE) begin : g_p
      assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
      assert_step_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_step && in_a == '0 |=> out_data == W'(1));
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
      assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
      assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid && out_ready |=> !out_valid);
    end else begin : g_c
      assert_step_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_step && in_a == '0 |-> out_data == W'(1));
      assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> out_valid);
      assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);
      assert_noflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !out_valid);
    end
  endgenerate
endmodule

bind tower_gf4k_mul tower_gf4k_mul_chk #(.PIPE(PIPE), .W(gf4k_pkg::SYM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_step(in_step), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tower_gf4k_mul_test.sv
module tower_gf4k_mul_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_step = 1'b0, out_ready = 1'b1;
  logic [11:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [11:0] out_data;
  logic c_valid = 1'b0, c_step = 1'b0;
  logic [11:0] c_a = '0, c_b = '0;
  logic c_iready, c_ovalid;
  logic [11:0] c_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tower_gf4k_mul #(.PIPE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_step(in_step), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  tower_gf4k_mul #(.PIPE(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(c_valid), .in_ready(c_iready),
    .in_a(c_a), .in_b(c_b), .in_step(c_step), .out_valid(c_ovalid),
    .out_ready(1'b1), .out_data(c_data));

  function automatic logic [5:0] m64(logic [5:0] a, logic [5:0] b);
    logic [6:0] bb = {1'b0, b};
    logic [5:0] c = '0;
    for (int i = 0; i < 6; i++) begin
      if (a[i]) c = c ^ bb[5:0];
      bb = bb << 1;
      if (bb[6]) bb = bb ^ 7'h43;
    end
    return c;
  endfunction

  function automatic logic [11:0] m4k(logic [11:0] a, logic [11:0] b);
    logic [5:0] hi, lo;
    hi = m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ m64(a[5:0], b[5:0]);
    lo = m64(m64(a[11:6], b[11:6]), 6'h21) ^ m64(a[5:0], b[5:0]);
    return {hi, lo};
  endfunction

  task automatic check(bit ok, string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(logic [11:0] a, logic [11:0] b, logic st, output logic [11:0] r);
    @(negedge clk);
    in_a = a; in_b = b; in_step = st; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = out_data;
    check(out_valid == 1'b1, "R7 valid", {11'd0, out_valid}, 12'd1);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R9 out_valid", {11'd0, out_valid}, 12'd0);
    check(in_ready == 1'b1, "R9 in_ready", {11'd0, in_ready}, 12'd1);
  endtask

  task automatic t_base_R1();
    logic [11:0] r;
    xfer(12'h020, 12'h002, 1'b0, r);
    check(r == 12'h003, "R1 x^6 reduction", r, 12'h003);
    xfer(12'h030, 12'h030, 1'b0, r);
    check(r == {6'h0, m64(6'h30, 6'h30)}, "R1 low-half product", r, {6'h0, m64(6'h30, 6'h30)});
  endtask

  task automatic t_model_R2();
    logic [11:0] r, a, b;
    for (int i = 0; i < 24; i++) begin
      a = 12'($urandom); b = 12'($urandom);
      if (i == 0) begin a = 12'hFC0; b = 12'hFC0; end
      if (i == 1) begin a = 12'h040; b = 12'h001; end
      xfer(a, b, 1'b0, r);
      check(r == m4k(a, b), "R2 tower product", r, m4k(a, b));
    end
  endtask

  task automatic t_ident_R3();
    logic [11:0] r, a;
    for (int i = 0; i < 4; i++) begin
      a = 12'($urandom);
      xfer(a, 12'h001, 1'b0, r);
      check(r == a, "R3 times one", r, a);
      xfer(12'h000, a, 1'b0, r);
      check(r == 12'h000, "R3 times zero", r, 12'h000);
    end
  endtask

  task automatic t_alg_R4();
    logic [11:0] a, b, c, ab, ba, ac, abc;
    for (int i = 0; i < 6; i++) begin
      a = 12'($urandom); b = 12'($urandom); c = 12'($urandom);
      xfer(a, b, 1'b0, ab);
      xfer(b, a, 1'b0, ba);
      check(ab == ba, "R4 commutative", ba, ab);
      xfer(a, c, 1'b0, ac);
      xfer(a, b ^ c, 1'b0, abc);
      check(abc == (ab ^ ac), "R4 distributive", abc, ab ^ ac);
    end
  endtask

  task automatic t_step_R5();
    logic [11:0] r, a;
    xfer(12'h001, 12'h5A5, 1'b1, r);
    check(r == 12'hE01, "R5 one step", r, 12'hE01);
    for (int i = 0; i < 5; i++) begin
      a = 12'($urandom) | 12'h100;
      xfer(a, 12'($urandom), 1'b1, r);
      check(r == m4k(a, 12'hE01), "R5 step product", r, m4k(a, 12'hE01));
    end
  endtask

  task automatic t_stepzero_R6();
    logic [11:0] r;
    xfer(12'h000, 12'hABC, 1'b1, r);
    check(r == 12'h001, "R6 zero step", r, 12'h001);
  endtask

  task automatic t_latency_R7();
    logic [11:0] r;
    xfer(12'h123, 12'h456, 1'b0, r);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 single beat", {11'd0, out_valid}, 12'd0);
    c_a = 12'h7E3; c_b = 12'h19C; c_step = 1'b0; c_valid = 1'b1;
    #1;
    check(c_ovalid && c_data == m4k(12'h7E3, 12'h19C), "R7 comb same cycle", c_data, m4k(12'h7E3, 12'h19C));
    c_a = 12'h000; c_step = 1'b1;
    #1;
    check(c_data == 12'h001, "R7 comb step zero", c_data, 12'h001);
    c_valid = 1'b0;
    #1;
    check(c_ovalid == 1'b0, "R7 comb idle", {11'd0, c_ovalid}, 12'd0);
  endtask

  task automatic t_backp_R8();
    logic [11:0] first;
    first = m4k(12'h2B7, 12'hC41);
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 12'h2B7; in_b = 12'hC41; in_step = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_a = 12'h0F0; in_b = 12'h00F;
    check(in_ready == 1'b0, "R8 in_ready low", {11'd0, in_ready}, 12'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid && out_data == first, "R8 hold", out_data, first);
      check(in_ready == 1'b0, "R8 blocked", {11'd0, in_ready}, 12'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == m4k(12'h0F0, 12'h00F), "R8 next after drain", out_data, m4k(12'h0F0, 12'h00F));
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drained", {11'd0, out_valid}, 12'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_R1();
    t_model_R2();
    t_ident_R3();
    t_alg_R4();
    t_step_R5();
    t_stepzero_R6();
    t_latency_R7();
    t_backp_R8();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 12'h0, 12'h1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule